// File: doc/BRIEF.md
# Serial Host Control Port

This block is the host-facing serial slave of a digital audio receiver. A microcontroller drives a serial clock, an active-high enable strobe and a data line. Each transfer opens with an 8-bit address that picks one of three transactions: a command write, a readout of the captured channel-status word, or a readout of the captured subcode Q word with its CRC flag. The last accepted command byte is held in a register. Fixed bits of that byte drive the receiver's control outputs: system stop, demodulator input choice, auxiliary output source and audio output format.

All serial pins are brought into the system clock domain through a synchronizer. A mode pin chooses between two host framings. Each framing has its own set of three address codes. In one the read line is open-drain: it only ever pulls low. In the other it is three-state: it drives both levels for the whole read phase. The read line comes out as separate enable and value signals, so the pad and the bench can resolve it. The readout words arrive on input ports from the neighbouring capture logic. The channel-status image is forced to zero while the PLL reports loss of lock.

Top module: `hostlink_ctrl`

## Requirements
- R1: Address and data bits are taken on rising serial-clock edges while the enable is high, least significant bit first. The command-write address is 0xF7 when the mode pin is low and 0xEA when it is high. The 8 command bits follow the address, bit 0 first, and are committed when the enable falls.
- R2: Command bit 1 drives `sys_stop` (1 = stopped). Command bit 2 drives `in_sel` (0 = input 1, 1 = input 2).
- R3: `aux_sel` = {bit 4, bit 3}, coded 0 = emphasis, 1 = validity flag, 2 = raw biphase of input 1, 3 = raw biphase of input 2.
- R4: `afmt_sel` = {bit 6, bit 5}. Command bits 0 and 7 have no effect on any output.
- R5: While `rst_n` is low, every control output is 0 and the read line is released (`sdo_oe` = 0).
- R6: A write leaves the command unchanged when it ends with fewer than 16 serial clocks. It also leaves it unchanged when its address belongs to the other mode.
- R7: The channel-status read address is 0xF8 (mode low) or 0xE9 (mode high). The 32-bit word is sent least significant bit first. In mode high a constant 1 flag bit comes before it. In mode low there is no flag bit.
- R8: The subcode read address is 0xF9 (mode low) or 0xE8 (mode high). It sends the CRC-good flag first, then the 80-bit word least significant bit first. Each read bit is valid before the rising serial-clock edge that follows it and changes after a falling edge.
- R9: In mode low, `sdo_oe` is 1 only while a 0 bit is being read, and `sdo_val` is then 0.
- R10: In mode high, `sdo_oe` is 1 through the whole read phase and `sdo_val` carries the bit. In both modes `sdo_oe` is 0 outside a read, including during command writes.
- R11: While `lock_ok` is low, the channel-status readout shows all-zero bits. This includes the rest of a read already in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 1 | Host framing: 0 open-drain read, 1 three-state read |
| sck | input | 1 | Host serial clock |
| sen | input | 1 | Host enable/latch strobe, active high |
| sdi | input | 1 | Host serial data in |
| sdo_oe | output | 1 | Read line drive enable |
| sdo_val | output | 1 | Read line driven value |
| cs_word | input | 32 | Captured channel-status bits |
| lock_ok | input | 1 | PLL lock indication |
| sq_word | input | 80 | Captured subcode Q bits |
| sq_crc_ok | input | 1 | Subcode CRC check result |
| sys_stop | output | 1 | System stop control |
| in_sel | output | 1 | Demodulator input select |
| aux_sel | output | 2 | Auxiliary output source |
| afmt_sel | output | 2 | Audio output format |

## Verification
Command writes are sent in both framings with one-hot bytes, so that each control field is shown to come from its own bit. Bytes with only bits 0 and 7 set, or with all bits set, show the ignored bits and the fields' independence. Truncated writes and writes sent with the other framing's address show that the command register holds its value. Channel-status and subcode readouts are run in both framings with asymmetric words and both CRC flag values, which exposes bit-order, flag-presence and driver-style faults. Dropping lock before a read and again partway through one separates a cleared shift register from a stale one.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;

   localparam int ADDR_W = 8;

   typedef enum logic [1:0] {
      XFER_NONE,
      XFER_CMD,
      XFER_CS,
      XFER_SQ
   } xfer_t;

   // Address decode; each host framing owns its own code set.
   function automatic xfer_t decode_addr(input logic [ADDR_W-1:0] a, input logic mode);
      xfer_t k;
      k = XFER_NONE;
      if (!mode) begin
         case (a)
            8'hF7:   k = XFER_CMD;
            8'hF8:   k = XFER_CS;
            8'hF9:   k = XFER_SQ;
            default: k = XFER_NONE;
         endcase
      end else begin
         case (a)
            8'hEA:   k = XFER_CMD;
            8'hE9:   k = XFER_CS;
            8'hE8:   k = XFER_SQ;
            default: k = XFER_NONE;
         endcase
      end
      return k;
   endfunction

endpackage

// File: rtl/hostlink_sync.sv
module hostlink_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1)      begin : g_bad_w  $error("hostlink_sync: W must be at least 1"); end
      if (STAGES < 1) begin : g_bad_st $error("hostlink_sync: STAGES must be at least 1"); end
   endgenerate

   logic [W-1:0] pipe [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else if (s == 0) pipe[s] <= d;
            else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/hostlink_rx.sv
module hostlink_rx
   import hostlink_pkg::*;
#(
   parameter int CMD_W = 8,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_sel,
   input  logic             en_s,
   input  logic             sck_s,
   input  logic             din_s,
   output logic             sck_rise,
   output logic             sck_fall,
   output logic             load,
   output xfer_t            kind,
   output logic [CMD_W-1:0] cmd
);

   localparam logic [CNT_W-1:0] L_ADDR_LAST = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0] L_ADDR      = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0] L_CMD_DONE  = CNT_W'(ADDR_W + CMD_W);
   localparam logic [CNT_W-1:0] L_CNT_MAX   = {CNT_W{1'b1}};

   generate
      if ((2 ** CNT_W) <= (ADDR_W + CMD_W + 1)) begin : g_bad_cnt
         $error("hostlink_rx: CNT_W too narrow for the command frame");
      end
   endgenerate

   logic              sck_d, en_d;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] addr_sr;
   logic [ADDR_W-1:0] addr_full;
   logic [CMD_W-1:0]  data_sr;
   logic [CMD_W-1:0]  cmd_q;
   xfer_t             kind_q;
   logic              load_q;
   logic              en_fall;

   assign sck_rise  = sck_s & ~sck_d;
   assign sck_fall  = ~sck_s & sck_d;
   assign en_fall   = en_d & ~en_s;
   assign addr_full = {din_s, addr_sr[ADDR_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d   <= 1'b0;
         en_d    <= 1'b0;
         cnt     <= '0;
         addr_sr <= '0;
         data_sr <= '0;
         cmd_q   <= '0;
         kind_q  <= XFER_NONE;
         load_q  <= 1'b0;
      end else begin
         sck_d  <= sck_s;
         en_d   <= en_s;
         load_q <= 1'b0;
         if (!en_s) begin
            cnt    <= '0;
            kind_q <= XFER_NONE;
            if (en_fall && kind_q == XFER_CMD && cnt >= L_CMD_DONE) cmd_q <= data_sr;
         end else if (sck_rise) begin
            if (cnt != L_CNT_MAX) cnt <= cnt + 1'b1;
            if (cnt < L_ADDR) addr_sr <= addr_full;
            if (cnt == L_ADDR_LAST) begin
               kind_q <= decode_addr(addr_full, mode_sel);
               load_q <= 1'b1;
            end else if (kind_q == XFER_CMD && cnt >= L_ADDR && cnt < L_CMD_DONE) begin
               data_sr <= {din_s, data_sr[CMD_W-1:1]};
            end
         end
      end
   end

   assign load = load_q;
   assign kind = kind_q;
   assign cmd  = cmd_q;

   // R6: the command register moves only on a strobe release
   p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_fall |=> $stable(cmd_q));

   // R1: bit counting restarts with every new strobe
   p_cnt_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> (cnt == '0));

endmodule

// File: rtl/hostlink_tx.sv
module hostlink_tx
   import hostlink_pkg::*;
#(
   parameter int CS_W = 32,
   parameter int SQ_W = 80
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_sel,
   input  logic            en_s,
   input  logic            sck_rise,
   input  logic            sck_fall,
   input  logic            load,
   input  xfer_t           kind,
   input  logic [CS_W-1:0] cs_word,
   input  logic            lock_ok,
   input  logic [SQ_W-1:0] sq_word,
   input  logic            sq_crc_ok,
   output logic            rd_oe,
   output logic            rd_val
);

   localparam int RD_W = 1 + ((CS_W > SQ_W) ? CS_W : SQ_W);

   generate
      if (CS_W < 1 || SQ_W < 1) begin : g_bad_w
         $error("hostlink_tx: readout widths must be positive");
      end
   endgenerate

   logic [RD_W-1:0] shreg;
   logic [RD_W-1:0] cs_img, sq_img;
   logic            rd_on, armed, rd_cs;

   always_comb begin
      if (!lock_ok)      cs_img = '0;
      else if (mode_sel) cs_img = RD_W'({cs_word, 1'b1});
      else               cs_img = RD_W'(cs_word);
      sq_img = RD_W'({sq_word, sq_crc_ok});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         rd_on <= 1'b0;
         armed <= 1'b0;
         rd_cs <= 1'b0;
      end else if (!en_s) begin
         rd_on <= 1'b0;
         armed <= 1'b0;
         rd_cs <= 1'b0;
      end else if (load && (kind == XFER_CS || kind == XFER_SQ)) begin
         rd_on <= 1'b1;
         armed <= 1'b0;
         rd_cs <= (kind == XFER_CS);
         shreg <= (kind == XFER_CS) ? cs_img : sq_img;
      end else begin
         if (rd_cs && !lock_ok)              shreg <= '0;
         else if (sck_fall && rd_on && armed) shreg <= shreg >> 1;
         if (sck_rise && rd_on) armed <= 1'b1;
      end
   end

   // Open-drain framing pulls low only; three-state framing drives both levels.
   assign rd_oe  = rd_on & (mode_sel | ~shreg[0]);
   assign rd_val = mode_sel & shreg[0];

   // R11: a lost lock empties the status image on the next cycle
   p_cs_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (en_s && rd_cs && !lock_ok && !load) |=> (shreg == '0));

   // R8: the read image holds between falling serial edges
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_s && rd_on && !sck_fall && !load && lock_ok) |=> $stable(shreg));

endmodule

// File: rtl/hostlink_ctrl.sv
module hostlink_ctrl
   import hostlink_pkg::*;
#(
   parameter int CS_W        = 32,
   parameter int SQ_W        = 80,
   parameter int CMD_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_sel,
   input  logic            sck,
   input  logic            sen,
   input  logic            sdi,
   output logic            sdo_oe,
   output logic            sdo_val,
   input  logic [CS_W-1:0] cs_word,
   input  logic            lock_ok,
   input  logic [SQ_W-1:0] sq_word,
   input  logic            sq_crc_ok,
   output logic            sys_stop,
   output logic            in_sel,
   output logic [1:0]      aux_sel,
   output logic [1:0]      afmt_sel
);

   localparam int RD_W  = 1 + ((CS_W > SQ_W) ? CS_W : SQ_W);
   localparam int CNT_W = $clog2(ADDR_W + CMD_W + RD_W + 2) + 1;

   generate
      if (CMD_W < 7) begin : g_bad_cmd
         $error("hostlink_ctrl: command byte must hold bits 1 to 6");
      end
   endgenerate

   logic [2:0]       pins_s;
   logic             sck_rise, sck_fall, load;
   xfer_t            kind;
   logic [CMD_W-1:0] cmd;

   hostlink_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sen, sck, sdi}),
      .q     (pins_s)
   );

   hostlink_rx #(.CMD_W(CMD_W), .CNT_W(CNT_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_sel (mode_sel),
      .en_s     (pins_s[2]),
      .sck_s    (pins_s[1]),
      .din_s    (pins_s[0]),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .load     (load),
      .kind     (kind),
      .cmd      (cmd)
   );

   hostlink_tx #(.CS_W(CS_W), .SQ_W(SQ_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .en_s      (pins_s[2]),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .load      (load),
      .kind      (kind),
      .cs_word   (cs_word),
      .lock_ok   (lock_ok),
      .sq_word   (sq_word),
      .sq_crc_ok (sq_crc_ok),
      .rd_oe     (sdo_oe),
      .rd_val    (sdo_val)
   );

   assign sys_stop = cmd[1];
   assign in_sel   = cmd[2];
   assign aux_sel  = cmd[4:3];
   assign afmt_sel = cmd[6:5];

   // R10: the read line is released once the strobe is seen low
   p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pins_s[2] |=> !sdo_oe);

   // R9: in open-drain framing a high level is never driven
   p_od_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_sel && sdo_oe) |-> !sdo_val);

   // R7: a readout image is only loaded after an address has been received
   p_load_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && kind == XFER_CS) |-> pins_s[2]);

endmodule

// File: tb/hostlink_ctrl_test.sv
module hostlink_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_sel = 1'b0;
   logic        sck = 1'b0, sen = 1'b0, sdi = 1'b0;
   logic        sdo_oe, sdo_val;
   logic [31:0] cs_word = 32'hA5C3_1E69;
   logic        lock_ok = 1'b1;
   logic [79:0] sq_word = 80'h9E37_0F1D_62B8_C405_7A13;
   logic        sq_crc_ok = 1'b1;
   logic        sys_stop, in_sel;
   logic [1:0]  aux_sel, afmt_sel;

   int n_run = 0, n_fail = 0;
   logic [127:0] got;
   logic         drv_ok;

   always #2 clk = ~clk;

   hostlink_ctrl uut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
      .sck(sck), .sen(sen), .sdi(sdi),
      .sdo_oe(sdo_oe), .sdo_val(sdo_val),
      .cs_word(cs_word), .lock_ok(lock_ok),
      .sq_word(sq_word), .sq_crc_ok(sq_crc_ok),
      .sys_stop(sys_stop), .in_sel(in_sel),
      .aux_sel(aux_sel), .afmt_sel(afmt_sel)
   );

   // {command byte, expected {stop, in, aux[1:0], fmt[1:0]}}
   localparam logic [13:0] VEC [10] = '{
      {8'h02, 6'b1_0_00_00}, {8'h04, 6'b0_1_00_00}, {8'h08, 6'b0_0_01_00},
      {8'h10, 6'b0_0_10_00}, {8'h18, 6'b0_0_11_00}, {8'h20, 6'b0_0_00_01},
      {8'h40, 6'b0_0_00_10}, {8'h81, 6'b0_0_00_00}, {8'hFF, 6'b1_1_11_11},
      {8'h6A, 6'b1_0_01_11}
   };

   function automatic logic [5:0] outs();
      return {sys_stop, in_sel, aux_sel, afmt_sel};
   endfunction

   task automatic check(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input logic b);
      sdi = b;  wt(4);
      sck = 1'b1; wt(10);
      sck = 1'b0; wt(10);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) sbit(b[i]);
   endtask

   task automatic open_x(input logic [7:0] addr);
      sen = 1'b1; wt(8);
      send_byte(addr);
   endtask

   task automatic close_x();
      sen = 1'b0; wt(12);
   endtask

   task automatic write_cmd(input logic [7:0] addr, input logic [7:0] b, input int nbits);
      open_x(addr);
      for (int i = 0; i < nbits; i++) sbit(b[i % 8]);
      close_x();
   endtask

   // Samples the resolved line (pull-up when released) before each rising edge.
   task automatic read_bits(input int n);
      logic line;
      got = '0;
      drv_ok = 1'b1;
      for (int i = 0; i < n; i++) begin
         line = sdo_oe ? sdo_val : 1'b1;
         got[i] = line;
         if (mode_sel && !sdo_oe) drv_ok = 1'b0;
         if (!mode_sel && (sdo_val || (sdo_oe == line))) drv_ok = 1'b0;
         sbit(1'b0);
      end
   endtask

   initial begin
      #(4 * 190000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R5: reset state
      wt(5);
      check(outs() == 6'd0 && !sdo_oe, "R5 reset", {outs(), sdo_oe}, 0);
      rst_n = 1'b1; wt(5);

      // R1..R4: command vectors in both framings
      for (int m = 0; m < 2; m++) begin
         mode_sel = m[0];
         for (int v = 0; v < 10; v++) begin
            write_cmd(m[0] ? 8'hEA : 8'hF7, VEC[v][13:6], 8);
            check(outs() == VEC[v][5:0], "R1 R2 R3 R4 command decode",
                  outs(), VEC[v][5:0]);
         end
      end

      // R6: truncated write, then foreign-framing address
      mode_sel = 1'b0;
      write_cmd(8'hF7, 8'hFF, 8);
      write_cmd(8'hF7, 8'h00, 7);
      check(outs() == 6'h3F, "R6 short write", outs(), 6'h3F);
      write_cmd(8'hEA, 8'h00, 8);
      check(outs() == 6'h3F, "R6 foreign address", outs(), 6'h3F);

      // R10: no drive during a command write in three-state framing
      mode_sel = 1'b1;
      open_x(8'hEA);
      send_byte(8'h04);
      check(!sdo_oe, "R10 write no drive", sdo_oe, 0);
      close_x();
      check(outs() == 6'b010000, "R1 write mode high", outs(), 6'b010000);

      // R7 / R9: channel status, open-drain framing, no flag
      mode_sel = 1'b0;
      open_x(8'hF8);
      read_bits(32);
      close_x();
      check(got[31:0] == cs_word, "R7 cs mode low", got[31:0], cs_word);
      check(drv_ok, "R9 open-drain drive", drv_ok, 1);
      check(!sdo_oe, "R10 released after read", sdo_oe, 0);

      // R7 / R10: channel status, three-state framing, flag first
      mode_sel = 1'b1;
      open_x(8'hE9);
      read_bits(33);
      close_x();
      check(got[32:0] == {cs_word, 1'b1}, "R7 cs mode high", got[32:0], {cs_word, 1'b1});
      check(drv_ok, "R10 three-state drive", drv_ok, 1);
      check(!sdo_oe, "R10 released after read", sdo_oe, 0);

      // R8: subcode, both framings and both CRC flags
      sq_crc_ok = 1'b1;
      open_x(8'hE8);
      read_bits(81);
      close_x();
      check(got[80:0] == {sq_word, 1'b1}, "R8 subq mode high", got[80:0], {sq_word, 1'b1});
      mode_sel = 1'b0;
      sq_crc_ok = 1'b0;
      open_x(8'hF9);
      read_bits(81);
      close_x();
      check(got[80:0] == {sq_word, 1'b0}, "R8 subq mode low", got[80:0], {sq_word, 1'b0});
      check(drv_ok, "R9 open-drain subq", drv_ok, 1);

      // R11: lock lost before the read
      mode_sel = 1'b1;
      lock_ok = 1'b0;
      open_x(8'hE9);
      read_bits(33);
      close_x();
      check(got[32:0] == 33'd0, "R11 cs cleared", got[32:0], 0);

      // R11: lock lost partway through a read
      lock_ok = 1'b1;
      open_x(8'hE9);
      read_bits(8);
      check(got[7:0] == {cs_word[6:0], 1'b1}, "R11 cs head", got[7:0], {cs_word[6:0], 1'b1});
      lock_ok = 1'b0;
      wt(10);
      read_bits(25);
      close_x();
      check(got[24:0] == 25'd0, "R11 cs tail cleared", got[24:0], 0);
      lock_ok = 1'b1;

      // R5: reset clears a non-zero command
      mode_sel = 1'b0;
      write_cmd(8'hF7, 8'h7E, 8);
      check(outs() == 6'h3F, "R2 R3 R4 before reset", outs(), 6'h3F);
      rst_n = 1'b0; wt(3);
      check(outs() == 6'd0 && !sdo_oe, "R5 reset clears", outs(), 0);
      rst_n = 1'b1; wt(5);
      check(outs() == 6'd0, "R5 after release", outs(), 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule